// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM with Selectable Read Pipeline and Deselect Depth

This block is a single-port synchronous SRAM that a burst address generator feeds with one address per clock. Chip enable and the write controls are captured on the rising clock edge. A cycle with chip enable high and no write control is a read. A write either fills every byte lane at once or fills only the lanes chosen by per-lane strobes.

Two static mode inputs shape the read side. The first chooses how read data reaches the output. In flow-through mode the array output drives the bus directly. In pipelined mode the data passes through an extra output register, which adds one cycle of latency. The second mode input chooses when the bus is released after a deselect. In single-cycle mode the release comes one stage earlier than read data would arrive. In dual-cycle mode the release is delayed to the full read depth, and the last read word stays on the bus for one more cycle.

Output enable and the sleep input act on the bus at once, without waiting for a clock edge. A separate drive-enable output replaces tri-state control. The read data output is zero whenever drive-enable is low.

Top module: `sync_sram_core`

## Requirements
- R1: With `pipe_mode`=0, a read captured at clock edge E drives `drive_en`=1 and the word at that address on `rdata` in the cycle after E.
- R2: With `pipe_mode`=1, a read captured at edge E first appears on `rdata` with `drive_en`=1 in the cycle after edge E+1.
- R3: Reads captured on consecutive edges give one new word per cycle, in address order, after the initial latency of R1 or R2.
- R4: With `dual_desel`=0, an idle cycle (`cs`=0) at edge E releases the bus (`drive_en`=0) after E in flow-through mode and after E+1 in pipelined mode.
- R5: With `dual_desel`=1, an idle cycle at edge E that directly follows a read keeps the last read word driven for one more cycle: until E+1 in flow-through mode and until E+2 in pipelined mode.
- R6: A write with `gw`=1 stores all byte lanes of `wdata` (lane i is bits [i*LANE_W +: LANE_W]), whatever `bw_lane` holds.
- R7: A write with `gw`=0 and `bw_en`=1 stores only the lanes whose `bw_lane` bit is 1. The other lanes keep their old contents.
- R8: A write cycle never drives the bus in flow-through mode. A read of the same address on the next edge returns the newly written data.
- R9: `oe`=0 forces `drive_en`=0 and `rdata`=0 at once, without waiting for a clock edge.
- R10: While `sleep`=1, `drive_en`=0 at once, and commands captured at that time neither write the array nor start a read.
- R11: After a synchronous reset, `drive_en`=0 until a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| dual_desel | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| cs | input | 1 | Chip enable, sampled on the clock edge |
| addr | input | AW | Word address |
| gw | input | 1 | Write all lanes |
| bw_en | input | 1 | Write the lanes selected by bw_lane |
| bw_lane | input | LANES | Per-lane write strobes |
| wdata | input | LANES*LANE_W | Write data |
| oe | input | 1 | Output enable, asynchronous |
| sleep | input | 1 | Sleep, asynchronous on the bus and blocking commands |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| drive_en | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is the dual-cycle hold in pipelined mode. It needs a read followed directly by an idle cycle, and the bus must stay driven for two edges after the idle command while nothing new enters the pipeline. The stimulus runs the same command script in all four mode combinations: back-to-back reads, a read then idles, a write then a read of the same address, and partial-lane writes. The bench model predicts bus state and data for every cycle. Output enable and sleep are toggled between edges, and the bus is sampled just after each toggle. A write issued while sleep is high is checked by reading the untouched address back afterwards.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sram_cmd_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs,
  input  logic             gw,
  input  logic             bw_en,
  input  logic [LANES-1:0] bw_lane,
  input  logic             sleep,
  output sram_cmd_e        cmd,
  output logic [LANES-1:0] lane_we
);
  always_comb begin
    cmd     = CMD_IDLE;
    lane_we = '0;
    if (cs && !sleep) begin
      if (gw || bw_en) begin
        cmd     = CMD_WRITE;
        lane_we = gw ? {LANES{1'b1}} : bw_lane;
      end else begin
        cmd = CMD_READ;
      end
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lane_we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)      rd_q[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/sram_out_ctl.sv
module sram_out_ctl
  import sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              dual_desel,
  input  sram_cmd_e         cmd,
  input  logic [DATA_W-1:0] arr_q,
  output logic              drv,
  output logic [DATA_W-1:0] dout
);
  logic              rd_s1, rd_s2, ds_s1;
  logic [DATA_W-1:0] pipe_q;
  logic              is_rd, is_ds, drv_ft_nxt, drv_pipe_nxt;

  assign is_rd = (cmd == CMD_READ);
  assign is_ds = (cmd == CMD_IDLE);

  always_comb begin
    drv_ft_nxt   = is_rd || (dual_desel && rd_s1 && is_ds);
    drv_pipe_nxt = rd_s1 || (dual_desel && rd_s2 && ds_s1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s1  <= 1'b0;
      rd_s2  <= 1'b0;
      ds_s1  <= 1'b1;
      drv    <= 1'b0;
      pipe_q <= '0;
    end else begin
      rd_s1 <= is_rd;
      rd_s2 <= rd_s1;
      ds_s1 <= is_ds;
      drv   <= pipe_mode ? drv_pipe_nxt : drv_ft_nxt;
      if (rd_s1) pipe_q <= arr_q;
    end
  end

  assign dout = pipe_mode ? pipe_q : arr_q;

  AST_FT_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && cmd == CMD_READ) |=> drv); // R1
  AST_PIPE_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && cmd == CMD_READ) |=> ##1 drv); // R2
  AST_FT_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && cmd == CMD_WRITE) |=> !drv); // R8
  AST_SCD_FT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && !dual_desel && cmd == CMD_IDLE) |=> !drv); // R4
  AST_DCD_PIPE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && dual_desel && rd_s1 && cmd == CMD_IDLE) |=> ##1 drv); // R5
endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
  import sram_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              dual_desel,
  input  logic              cs,
  input  logic [AW-1:0]     addr,
  input  logic              gw,
  input  logic              bw_en,
  input  logic [LANES-1:0]  bw_lane,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              drive_en
);
  sram_cmd_e         cmd;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] arr_q, dout;
  logic              drv;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .cs(cs), .gw(gw), .bw_en(bw_en), .bw_lane(bw_lane), .sleep(sleep),
    .cmd(cmd), .lane_we(lane_we)
  );

  sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rd_en(cmd == CMD_READ), .lane_we(lane_we), .addr(addr),
    .wdata(wdata), .rd_q(arr_q)
  );

  sram_out_ctl #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .dual_desel(dual_desel),
    .cmd(cmd), .arr_q(arr_q), .drv(drv), .dout(dout)
  );

  assign drive_en = drv && oe && !sleep;
  assign rdata    = drive_en ? dout : '0;

  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (lane_we == '0)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !drive_en); // R11
endmodule

// File: tb/sync_sram_core_tb.sv
module sync_sram_core_tb;
  localparam int DEPTH = 16, LANES = 4, LANE_W = 9, AW = 4, DW = 36;

  logic clk = 1'b0, rst = 1'b1, pipe_mode = 1'b0, dual_desel = 1'b0;
  logic cs = 1'b0, gw = 1'b0, bw_en = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LANES-1:0] bw_lane = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic drive_en;

  sync_sram_core #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .dual_desel(dual_desel),
    .cs(cs), .addr(addr), .gw(gw), .bw_en(bw_en), .bw_lane(bw_lane),
    .wdata(wdata), .oe(oe), .sleep(sleep), .rdata(rdata), .drive_en(drive_en)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] mem_m [DEPTH];
  int h0 = 0, h1 = 0, h2 = 0;           // 0 idle, 1 read, 2 write
  logic [DW-1:0] ft_data = '0, pipe_data = '0;

  task automatic check_bus(input string tag);
    logic exp_drv, exp_en;
    logic [DW-1:0] exp_d;
    if (!pipe_mode) exp_drv = (h0 == 1) || (dual_desel && h1 == 1 && h0 == 0);
    else            exp_drv = (h1 == 1) || (dual_desel && h2 == 1 && h1 == 0);
    exp_en = exp_drv && oe && !sleep;
    exp_d  = exp_en ? (pipe_mode ? pipe_data : ft_data) : '0;
    checks++;
    if (drive_en !== exp_en || rdata !== exp_d) begin
      failures++;
      $display("FAIL %s: drive_en=%0b exp=%0b rdata=%h exp=%h (pipe=%0b dual=%0b)",
               tag, drive_en, exp_en, rdata, exp_d, pipe_mode, dual_desel);
    end
  endtask

  // kind: 0 idle, 1 read, 2 write
  task automatic step(input int kind, input int a, input logic g, input logic b,
                      input logic [LANES-1:0] ln, input logic [DW-1:0] wd,
                      input string tag);
    int eff;
    cs = (kind != 0); addr = AW'(a); gw = g; bw_en = b; bw_lane = ln; wdata = wd;
    eff = sleep ? 0 : kind;
    if (h0 == 1) pipe_data = ft_data;
    if (eff == 1) ft_data = mem_m[a];
    if (eff == 2)
      for (int l = 0; l < LANES; l++)
        if (g || ln[l]) mem_m[a][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
    h2 = h1; h1 = h0; h0 = eff;
    @(posedge clk);
    @(negedge clk);
    check_bus(tag);
  endtask

  task automatic rd(input int a, input string tag);
    step(1, a, 1'b0, 1'b0, '0, '0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  task automatic do_reset(input logic pm, input logic dd);
    @(negedge clk);
    rst = 1'b1; cs = 1'b0; pipe_mode = pm; dual_desel = dd; oe = 1'b1; sleep = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    h0 = 0; h1 = 0; h2 = 0;
    check_bus("R11");
    idle("R11");
  endtask

  task automatic run_mode(input logic pm, input logic dd);
    string rd_tag, ds_tag;
    rd_tag = pm ? "R2" : "R1";
    ds_tag = dd ? "R5" : "R4";
    do_reset(pm, dd);
    for (int a = 0; a < DEPTH; a++)
      step(2, a, 1'b1, 1'b0, 4'b0000, {4{9'(a * 37 + pm * 5 + dd * 11)}}, "R6");
    idle("R8");
    for (int a = 0; a < 4; a++) rd(a, "R3");
    idle(ds_tag); idle(ds_tag); idle(ds_tag);
    rd(5, rd_tag); idle(ds_tag); idle(ds_tag); idle(ds_tag);
    step(2, 6, 1'b0, 1'b1, 4'b0101, 36'hA_BCDE_F123, "R7");
    rd(6, "R8"); idle("R7"); idle("R7"); idle("R7");
    step(2, 7, 1'b1, 1'b1, 4'b0010, 36'h5_5AA5_3C3C, "R6");
    rd(7, "R8"); rd(6, "R3"); rd(9, "R3"); idle(ds_tag); idle(ds_tag); idle(ds_tag);
    step(2, 9, 1'b0, 1'b1, 4'b1000, 36'hF_0000_0000, "R8");
    idle("R8"); rd(9, "R7"); idle(ds_tag); idle(ds_tag); idle(ds_tag);
    // asynchronous output enable
    rd(3, rd_tag); rd(4, rd_tag);
    oe = 1'b0; #1 check_bus("R9");
    #1 oe = 1'b1; #1 check_bus("R9");
    idle("R9"); idle(ds_tag); idle(ds_tag);
    // sleep blocks a write and gates the bus
    rd(2, rd_tag);
    sleep = 1'b1; #1 check_bus("R10");
    step(2, 2, 1'b1, 1'b0, '0, 36'h0_DEAD_BEEF, "R10");
    rd(2, "R10");
    sleep = 1'b0; #1 check_bus("R10");
    idle("R10"); idle("R10"); rd(2, "R10"); idle("R10"); idle("R10"); idle("R10");
  endtask

  initial begin
    run_mode(1'b0, 1'b0);
    run_mode(1'b0, 1'b1);
    run_mode(1'b1, 1'b0);
    run_mode(1'b1, 1'b1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule